// File: doc/BRIEF.md
# MSI Doorbell Interrupt-Pulse Frame

This block is a 4 KB memory-mapped register frame. It turns message-signalled interrupt writes into single-cycle pulses on a bank of shared peripheral interrupt lines. A simple register bus presents one access per cycle. The access carries a valid strobe, a read/write flag, a 12-bit byte offset, an access size in bytes and 32-bit little-endian write data. Read data returns one cycle later.

The frame owns a contiguous range of interrupt IDs. The range starts at `BASE_SPI + 32` and spans `NUM_LINES` lines. A type word reports the range to software. A doorbell write names an absolute interrupt ID. The frame converts that ID to a local line index and pulses the matching output for one clock. An ID outside the range is silently dropped. An identification word reads as a fixed value. The optional identification area and every unmapped offset read as zero.

Both parameters are checked when the design is elaborated:
- `NUM_LINES` must lie between 1 and 128.
- `BASE_SPI + 32 + NUM_LINES` must not exceed 1020.

An illegal configuration stops the build. Defaults are `BASE_SPI = 0` and `NUM_LINES = 64`.

Top module: `msi_pulse_frame`

## Requirements
- R1: While reset is high and in the first cycle after it, `irq_pulse` is all zero and `rd_data` is zero.
- R2: A 4-byte read at offset 0x008 returns, in the next cycle, a type word. Bits [31:16] hold `BASE_SPI + 32` and bits [15:0] hold `NUM_LINES`.
- R3: A 4-byte read at offset 0xFCC returns 0x0510_0000 in the next cycle. This is the value 0x51 in bits [31:20], with all other bits zero.
- R4: A 4-byte read anywhere in offsets 0xFD0 to 0xFFC, or at any offset other than 0x008 and 0xFCC, returns zero in the next cycle.
- R5: A read whose size is not 4 returns zero in the next cycle, whatever its offset.
- R6: A doorbell is a write at offset 0x040 with size 2 or 4. Let `id` be bits [9:0] of its write data. If `BASE_SPI + 32 <= id < BASE_SPI + 32 + NUM_LINES`, then in the next cycle exactly bit `id - (BASE_SPI + 32)` of `irq_pulse` is high, and it is low again one cycle later.
- R7: A doorbell whose `id` (bits [9:0]; higher bits are ignored) is below `BASE_SPI + 32`, or at least `BASE_SPI + 32 + NUM_LINES`, leaves `irq_pulse` all zero.
- R8: A write at offset 0x040 with a size other than 2 or 4 leaves `irq_pulse` all zero. So does a write at any other offset.
- R9: Doorbells on consecutive cycles each produce their own one-cycle pulse, in order.
- R10: In a cycle that does not follow a read access, `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte offset inside the frame |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data, little-endian |
| rd_data | output | 32 | Read data, valid one cycle after a read |
| irq_pulse | output | NUM_LINES | One-cycle interrupt pulses, one bit per line |

## Verification
Read results appear exactly one clock after the access cycle. A doorbell pulse appears one clock after the write and must be gone one clock later. Inputs change on the falling edge, and outputs are sampled at the following falling edge. Each read result and each pulse is therefore compared in the one cycle where it is due. For doorbells, the cycle after that is also checked, to show the pulse has cleared.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;

    localparam logic [11:0] OFS_TYPE     = 12'h008;
    localparam logic [11:0] OFS_DOORBELL = 12'h040;
    localparam logic [11:0] OFS_IDENT    = 12'hFCC;
    localparam logic [11:0] OFS_OPTID_LO = 12'hFD0;
    localparam logic [11:0] OFS_OPTID_HI = 12'hFFC;

    localparam logic [31:0] IDENT_WORD   = 32'h0510_0000;
    localparam int          ID_OFFSET    = 32;
    localparam int          MAX_LINES    = 128;
    localparam int          MAX_ID_LIMIT = 1020;

    typedef enum logic [1:0] {
        RD_ZERO  = 2'd0,
        RD_TYPE  = 2'd1,
        RD_IDENT = 2'd2
    } rd_sel_e;

    typedef struct packed {
        logic       hit;
        logic [9:0] idx;
    } db_decode_t;

    function automatic logic read_size_ok(input logic [2:0] size);
        return size == 3'd4;
    endfunction

    function automatic logic write_size_ok(input logic [2:0] size);
        return (size == 3'd2) || (size == 3'd4);
    endfunction

    function automatic rd_sel_e classify_read(input logic [11:0] addr);
        rd_sel_e sel;
        if (addr == OFS_TYPE)
            sel = RD_TYPE;
        else if (addr == OFS_IDENT)
            sel = RD_IDENT;
        else
            sel = RD_ZERO;  // optional id area and unmapped offsets
        return sel;
    endfunction

endpackage

// File: rtl/msi_read_port.sv
module msi_read_port
    import msi_frame_pkg::*;
#(
    parameter int FIRST_ID  = 32,
    parameter int NUM_LINES = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_en,
    input  logic [11:0] addr,
    input  logic [2:0]  size,
    output logic [31:0] rd_data
);
    localparam logic [15:0] FIRST_W = 16'(FIRST_ID);
    localparam logic [15:0] COUNT_W = 16'(NUM_LINES);
    localparam logic [31:0] TYPE_WORD = {FIRST_W, COUNT_W};

    rd_sel_e     sel;
    logic [31:0] rd_next;

    always_comb begin
        sel     = classify_read(addr);
        rd_next = '0;
        if (rd_en && read_size_ok(size)) begin
            unique case (sel)
                RD_TYPE:  rd_next = TYPE_WORD;
                RD_IDENT: rd_next = IDENT_WORD;
                default:  rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else
            rd_data <= rd_next;
    end
endmodule

// File: rtl/msi_doorbell.sv
module msi_doorbell
    import msi_frame_pkg::*;
#(
    parameter int FIRST_ID  = 32,
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [11:0]          addr,
    input  logic [2:0]           size,
    input  logic [9:0]           msg_id,
    output logic [NUM_LINES-1:0] irq_pulse
);
    localparam logic [10:0] LO_ID = 11'(FIRST_ID);
    localparam logic [10:0] HI_ID = 11'(FIRST_ID + NUM_LINES);

    db_decode_t           dec;
    logic [NUM_LINES-1:0] pulse_next;

    always_comb begin
        dec.hit = wr_en && (addr == OFS_DOORBELL) && write_size_ok(size)
                  && ({1'b0, msg_id} >= LO_ID) && ({1'b0, msg_id} < HI_ID);
        dec.idx = msg_id - LO_ID[9:0];
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign pulse_next[i] = dec.hit && (dec.idx == 10'(i));
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq_pulse <= '0;
        else
            irq_pulse <= pulse_next;
    end
endmodule

// File: rtl/msi_pulse_frame.sv
module msi_pulse_frame
    import msi_frame_pkg::*;
#(
    parameter int BASE_SPI  = 0,
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [11:0]          bus_addr,
    input  logic [2:0]           bus_size,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          rd_data,
    output logic [NUM_LINES-1:0] irq_pulse
);
    localparam int FIRST_ID = BASE_SPI + ID_OFFSET;

    if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) begin : g_bad_count
        $error("msi_pulse_frame: NUM_LINES out of range 1..128");
    end
    if (BASE_SPI < 0 || FIRST_ID + NUM_LINES > MAX_ID_LIMIT) begin : g_bad_base
        $error("msi_pulse_frame: interrupt range passes ID 1020");
    end

    logic rd_en;
    logic wr_en;

    assign rd_en = bus_valid && !bus_write;
    assign wr_en = bus_valid &&  bus_write;

    msi_read_port #(.FIRST_ID(FIRST_ID), .NUM_LINES(NUM_LINES)) u_read (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .addr    (bus_addr),
        .size    (bus_size),
        .rd_data (rd_data)
    );

    msi_doorbell #(.FIRST_ID(FIRST_ID), .NUM_LINES(NUM_LINES)) u_bell (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (bus_addr),
        .size      (bus_size),
        .msg_id    (bus_wdata[9:0]),
        .irq_pulse (irq_pulse)
    );
endmodule

// File: rtl/msi_pulse_frame_chk.sv
module msi_pulse_frame_chk #(
    parameter int BASE_SPI  = 0,
    parameter int NUM_LINES = 64
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_valid,
    input logic                 bus_write,
    input logic [11:0]          bus_addr,
    input logic [2:0]           bus_size,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          rd_data,
    input logic [NUM_LINES-1:0] irq_pulse
);
    localparam int          FIRST_ID = BASE_SPI + 32;
    localparam logic [31:0] TYPE_EXP = {16'(FIRST_ID), 16'(NUM_LINES)};

    AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_pulse)) else $error("pulse not one-hot");  // R6

    AST_TYPE_WORD: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && bus_addr == 12'h008 && bus_size == 3'd4)
        |=> rd_data == TYPE_EXP) else $error("type word");  // R2

    AST_FIRST_LINE: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && bus_addr == 12'h040 && bus_size == 3'd4
         && bus_wdata[9:0] == 10'(FIRST_ID))
        |=> irq_pulse == NUM_LINES'(1)) else $error("first line pulse");  // R6

    AST_BAD_WR_SIZE: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && bus_size != 3'd2 && bus_size != 3'd4)
        |=> irq_pulse == '0) else $error("bad size write pulsed");  // R8

    AST_READ_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        (rd_data != '0) |-> $past(bus_valid && !bus_write && bus_size == 3'd4))
        else $error("read data without legal read");  // R10

    AST_PULSE_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        (irq_pulse != '0) |-> $past(bus_valid && bus_write && bus_addr == 12'h040))
        else $error("pulse without doorbell");  // R8
endmodule

bind msi_pulse_frame msi_pulse_frame_chk #(.BASE_SPI(BASE_SPI), .NUM_LINES(NUM_LINES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .rd_data   (rd_data),
    .irq_pulse (irq_pulse)
);

// File: tb/tb_msi_pulse_frame.sv
`timescale 1ns/1ps
module tb_msi_pulse_frame;
    localparam int BASE  = 16;
    localparam int LINES = 64;
    localparam int FIRST = BASE + 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_valid = 1'b0;
    logic             bus_write = 1'b0;
    logic [11:0]      bus_addr = '0;
    logic [2:0]       bus_size = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      rd_data;
    logic [LINES-1:0] irq_pulse;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    msi_pulse_frame #(.BASE_SPI(BASE), .NUM_LINES(LINES)) dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .rd_data(rd_data), .irq_pulse(irq_pulse)
    );

    function automatic logic [31:0] exp_read(input logic [11:0] a, input logic [2:0] s);
        if (s != 3'd4) return 32'h0;
        if (a == 12'h008) return {16'(FIRST), 16'(LINES)};
        if (a == 12'hFCC) return 32'h0510_0000;
        return 32'h0;
    endfunction

    function automatic logic [LINES-1:0] exp_pulse(input logic [11:0] a, input logic [2:0] s,
                                                   input logic [31:0] d);
        int id;
        id = int'(d[9:0]);
        if (a != 12'h040 || !(s == 3'd2 || s == 3'd4)) return '0;
        if (id < FIRST || id >= FIRST + LINES) return '0;
        return LINES'(1) << (id - FIRST);
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_size = '0; bus_wdata = '0;
    endtask

    task automatic do_read(input string req, input logic [11:0] a, input logic [2:0] s);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = s; bus_wdata = '0;
        @(negedge clk);
        idle();
        chk(req, 128'(rd_data), 128'(exp_read(a, s)));
        @(negedge clk);
        chk("R10", 128'(rd_data), 128'h0);
    endtask

    task automatic do_write(input string req, input logic [11:0] a, input logic [2:0] s,
                            input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
        @(negedge clk);
        idle();
        chk(req, 128'(irq_pulse), 128'(exp_pulse(a, s, d)));
        chk("R10", 128'(rd_data), 128'h0);
        @(negedge clk);
        chk({req, " clear"}, 128'(irq_pulse), 128'h0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk("R1 pulse in reset", 128'(irq_pulse), 128'h0);
        chk("R1 rdata in reset", 128'(rd_data), 128'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pulse after reset", 128'(irq_pulse), 128'h0);
        chk("R1 rdata after reset", 128'(rd_data), 128'h0);

        do_read("R2 type word", 12'h008, 3'd4);
        chk("R2 literal", 128'(exp_read(12'h008, 3'd4)), 128'h0030_0040);
        do_read("R3 ident word", 12'hFCC, 3'd4);
        do_read("R4 optional id low", 12'hFD0, 3'd4);
        do_read("R4 optional id high", 12'hFFC, 3'd4);
        do_read("R4 unmapped", 12'h100, 3'd4);
        do_read("R4 doorbell readback", 12'h040, 3'd4);
        do_read("R5 size 2 type", 12'h008, 3'd2);
        do_read("R5 size 1 ident", 12'hFCC, 3'd1);

        do_write("R6 first id", 12'h040, 3'd4, 32'(FIRST));
        do_write("R6 last id", 12'h040, 3'd4, 32'(FIRST + LINES - 1));
        do_write("R6 size 2", 12'h040, 3'd2, 32'(FIRST + 5));
        do_write("R7 high bits ignored", 12'h040, 3'd4, 32'hFFFF_FC00 | 32'(FIRST + 7));
        do_write("R7 below range", 12'h040, 3'd4, 32'(FIRST - 1));
        do_write("R7 above range", 12'h040, 3'd4, 32'(FIRST + LINES));
        do_write("R8 size 1", 12'h040, 3'd1, 32'(FIRST + 3));
        do_write("R8 size 3", 12'h040, 3'd3, 32'(FIRST + 3));
        do_write("R8 other offset", 12'h044, 3'd4, 32'(FIRST + 3));

        // R9: back-to-back doorbells
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 12'h040; bus_size = 3'd4;
        bus_wdata = 32'(FIRST + 2);
        @(negedge clk);
        bus_wdata = 32'(FIRST + 9);
        chk("R9 first pulse", 128'(irq_pulse), 128'(LINES'(1) << 2));
        @(negedge clk);
        idle();
        chk("R9 second pulse", 128'(irq_pulse), 128'(LINES'(1) << 9));
        @(negedge clk);
        chk("R9 clear", 128'(irq_pulse), 128'h0);

        for (int n = 0; n < 300; n++) begin
            logic [2:0]  s;
            logic [31:0] d;
            logic [11:0] a;
            s = 3'($urandom_range(0, 4));
            if ($urandom_range(0, 3) == 0)
                d = $urandom();
            else
                d = 32'($urandom_range(FIRST - 4, FIRST + LINES + 4));
            a = ($urandom_range(0, 7) == 0) ? 12'($urandom()) : 12'h040;
            do_write("R6/R7/R8 random write", a, s, d);
            case ($urandom_range(0, 4))
                0: a = 12'h008;
                1: a = 12'hFCC;
                2: a = 12'hFD0 + 12'($urandom_range(0, 11) * 4);
                default: a = 12'($urandom());
            endcase
            s = ($urandom_range(0, 2) != 0) ? 3'd4 : 3'($urandom_range(0, 7));
            do_read("R2/R3/R4/R5 random read", a, s);
        end

        summary();
    end
endmodule